// File: doc/BRIEF.md
# Saturating 64-by-32 Divider

This unit divides a 64-bit dividend by a 32-bit divisor for the integer divide instructions of a 32-bit core. The upper half of the dividend comes from a high-word register and the lower half from the first operand. The divisor is the second operand. A mode input selects unsigned or two's-complement signed division. The 32-bit quotient truncates toward zero. When the true quotient does not fit in 32 bits, the unit clamps it to the nearest representable limit and raises an overflow bit.

A start pulse is accepted only while the unit is idle. The operands, the mode and the flag-update select are captured on that edge. A normal divide then produces one quotient bit per cycle, working on operand magnitudes, and fixes the sign and the saturation in a final cycle. Two cases skip the iteration and finish at once: a zero divisor, and the signed most-negative dividend divided by minus one. A zero divisor reports a trap instead of a result. The condition-code outputs are a registered copy of the last committed quotient and overflow bit, updated only for requests that asked for it.

Top module: `sat_divider`

## Requirements
- R1: The dividend is {hi_i, opa_i}, with hi_i in bits 63..32, and the divisor is opb_i. In unsigned mode (signed_i=0) a quotient that fits in 32 bits appears exactly on quot_o, with ovf_o=0.
- R2: A zero divisor, in either mode, completes with dz_trap_o=1 together with done_o. In that case quot_o=0, ovf_o=0, and cc_quot_o and cc_ovf_o keep their earlier values.
- R3: In unsigned mode, a quotient above 0xFFFFFFFF gives quot_o=0xFFFFFFFF and ovf_o=1.
- R4: In signed mode (signed_i=1), the quotient truncates toward zero and is negative when the operand signs differ. If it lies in [-2^31, 2^31-1] it is exact, with ovf_o=0.
- R5: In signed mode, a quotient above 2^31-1 gives 0x7FFFFFFF and a quotient below -2^31 gives 0x80000000, both with ovf_o=1.
- R6: In signed mode, the dividend 0x8000000000000000 divided by 0xFFFFFFFF (minus one) gives 0x7FFFFFFF with ovf_o=1, and takes the short latency of R8.
- R7: If setcc_i was high on the accepting edge and no trap occurs, cc_quot_o and cc_ovf_o take the quot_o and ovf_o values of the same done cycle. Otherwise they hold their values.
- R8: done_o is high in the cycle that follows the 65th rising edge after the accepting edge for an iterated divide. For a zero divisor or the R6 case, it is high in the cycle after the first edge.
- R9: busy_o is high from the edge that accepts start_i until the edge that raises done_o, and low in the done cycle. A start_i while busy_o=1 is ignored, and its operands have no effect on any later result. A start in the done cycle is accepted.
- R10: done_o lasts exactly one cycle, and dz_trap_o is never high without done_o. quot_o and ovf_o change only in a done cycle.
- R11: While reset is held, busy_o, done_o, dz_trap_o, quot_o, ovf_o, cc_quot_o and cc_ovf_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a divide; accepted only when busy_o is low |
| signed_i | input | 1 | 1 selects signed division, 0 selects unsigned |
| setcc_i | input | 1 | 1 commits the result to the condition-code outputs |
| hi_i | input | 32 | Dividend bits 63..32 |
| opa_i | input | 32 | Dividend bits 31..0 |
| opb_i | input | 32 | Divisor |
| busy_o | output | 1 | A divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| dz_trap_o | output | 1 | Divide-by-zero trap, only together with done_o |
| quot_o | output | 32 | Saturated quotient, held until the next completion |
| ovf_o | output | 1 | Quotient was clamped |
| cc_quot_o | output | 32 | Quotient last committed for condition codes |
| cc_ovf_o | output | 1 | Overflow bit last committed for condition codes |

## Verification
A wrong iteration count or a wrong control state moves done_o away from the exact edge given in R8, so a per-cycle comparison of busy_o and done_o catches it on that edge. A bad remainder or a bad quotient bit shows on quot_o only in the done cycle. Because of this, operands are chosen near every saturation boundary, with mixed signs and with small divisors, so that any wrong bit reaches the ports. A stale mode, sign or flag-select latch, or a start accepted while busy, shows up as a wrong quotient, a wrong clamp or a wrong condition-code value on the next completion.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

   // Control sequence of the iterative divider
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } div_state_e;

   // Outcome class decided on the accepting edge
   typedef enum logic [1:0] {
      K_NORM = 2'd0,
      K_DZ   = 2'd1,
      K_SAT  = 2'd2
   } op_kind_e;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
   import sdiv_pkg::*;
#(
   parameter int ITER = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic short_i,
   output logic load_o,
   output logic step_o,
   output logic fin_o,
   output logic busy_o
);

   localparam int CW = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [CW-1:0] LAST = CW'(ITER - 1);

   div_state_e state_q, state_d;
   logic [CW-1:0] cnt_q;

   assign load_o = start_i && (state_q == ST_IDLE);
   assign step_o = (state_q == ST_RUN);
   assign fin_o  = (state_q == ST_FIN);
   assign busy_o = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (load_o) state_d = short_i ? ST_FIN : ST_RUN;
         ST_RUN:  if (cnt_q == LAST) state_d = ST_FIN;
         ST_FIN:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         if (load_o)      cnt_q <= '0;
         else if (step_o) cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            step_i,
   input  logic [2*DW-1:0] dvd_i,
   input  logic [DW-1:0]   dsr_i,
   output logic [2*DW-1:0] quo_o
);

   localparam int DW2 = 2 * DW;

   logic [DW-1:0]  rem_q, dsr_q;
   logic [DW2-1:0] acc_q;
   logic [DW:0]    shifted;
   logic [DW+1:0]  trial;
   logic           take;

   // Restoring step: shift one dividend bit into the partial remainder
   assign shifted = {rem_q, acc_q[DW2-1]};
   assign trial   = {1'b0, shifted} - {2'b00, dsr_q};
   assign take    = !trial[DW+1];
   assign quo_o   = acc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         dsr_q <= '0;
         acc_q <= '0;
      end else if (load_i) begin
         rem_q <= '0;
         dsr_q <= dsr_i;
         acc_q <= dvd_i;
      end else if (step_i) begin
         rem_q <= take ? trial[DW-1:0] : shifted[DW-1:0];
         acc_q <= {acc_q[DW2-2:0], take};
      end
   end

endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup #(
   parameter int DW = 32
) (
   input  logic [2*DW-1:0] mag_i,
   input  logic            neg_i,
   input  logic            signed_i,
   output logic [DW-1:0]   quot_o,
   output logic            ovf_o
);

   localparam int DW2 = 2 * DW;
   localparam logic [DW2-1:0] HALF    = {{DW{1'b0}}, 1'b1, {(DW-1){1'b0}}};
   localparam logic [DW2-1:0] POS_MAX = HALF - 1'b1;
   localparam logic [DW-1:0]  S_MAX   = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0]  S_MIN   = {1'b1, {(DW-1){1'b0}}};

   always_comb begin
      quot_o = mag_i[DW-1:0];
      ovf_o  = 1'b0;
      if (!signed_i) begin
         if (|mag_i[DW2-1:DW]) begin
            quot_o = '1;
            ovf_o  = 1'b1;
         end
      end else if (neg_i) begin
         if (mag_i > HALF) begin
            quot_o = S_MIN;
            ovf_o  = 1'b1;
         end else begin
            quot_o = -mag_i[DW-1:0];
         end
      end else if (mag_i > POS_MAX) begin
         quot_o = S_MAX;
         ovf_o  = 1'b1;
      end
   end

endmodule

// File: rtl/sat_divider.sv
module sat_divider
   import sdiv_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          signed_i,
   input  logic          setcc_i,
   input  logic [DW-1:0] hi_i,
   input  logic [DW-1:0] opa_i,
   input  logic [DW-1:0] opb_i,
   output logic          busy_o,
   output logic          done_o,
   output logic          dz_trap_o,
   output logic [DW-1:0] quot_o,
   output logic          ovf_o,
   output logic [DW-1:0] cc_quot_o,
   output logic          cc_ovf_o
);

   localparam int DW2  = 2 * DW;
   localparam int ITER = DW2;
   localparam logic [DW2-1:0] DVD_MIN = {1'b1, {(DW2-1){1'b0}}};
   localparam logic [DW-1:0]  S_MAX   = {1'b0, {(DW-1){1'b1}}};

   generate
      if (DW < 2) begin : g_bad_width
         $error("sat_divider: DW must be at least 2");
      end
   endgenerate

   logic [DW2-1:0] dvd_raw, dvd_mag, quo_mag;
   logic [DW-1:0]  dsr_mag, fx_quot;
   logic           sign_a, sign_b, is_zero, is_minneg, fx_ovf;
   logic           load, step, fin;
   op_kind_e       kind_d, kind_q;
   logic           sgn_q, neg_q, setcc_q;

   // Operand preparation: magnitudes and early-exit detection
   assign dvd_raw   = {hi_i, opa_i};
   assign sign_a    = signed_i & dvd_raw[DW2-1];
   assign sign_b    = signed_i & opb_i[DW-1];
   assign dvd_mag   = sign_a ? -dvd_raw : dvd_raw;
   assign dsr_mag   = sign_b ? -opb_i : opb_i;
   assign is_zero   = (opb_i == '0);
   assign is_minneg = signed_i && (dvd_raw == DVD_MIN) && (&opb_i);
   assign kind_d    = is_zero ? K_DZ : (is_minneg ? K_SAT : K_NORM);

   sdiv_ctrl #(.ITER(ITER)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .short_i (kind_d != K_NORM),
      .load_o  (load),
      .step_o  (step),
      .fin_o   (fin),
      .busy_o  (busy_o)
   );

   sdiv_core #(.DW(DW)) core_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .step_i (step),
      .dvd_i  (dvd_mag),
      .dsr_i  (dsr_mag),
      .quo_o  (quo_mag)
   );

   sdiv_fixup #(.DW(DW)) fixup_i (
      .mag_i    (quo_mag),
      .neg_i    (neg_q),
      .signed_i (sgn_q),
      .quot_o   (fx_quot),
      .ovf_o    (fx_ovf)
   );

   // Request attributes captured on the accepting edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sgn_q   <= 1'b0;
         neg_q   <= 1'b0;
         setcc_q <= 1'b0;
         kind_q  <= K_NORM;
      end else if (load) begin
         sgn_q   <= signed_i;
         neg_q   <= sign_a ^ sign_b;
         setcc_q <= setcc_i;
         kind_q  <= kind_d;
      end
   end

   // Result commit in the final cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_o    <= 1'b0;
         dz_trap_o <= 1'b0;
         quot_o    <= '0;
         ovf_o     <= 1'b0;
         cc_quot_o <= '0;
         cc_ovf_o  <= 1'b0;
      end else begin
         done_o    <= fin;
         dz_trap_o <= fin && (kind_q == K_DZ);
         if (fin) begin
            unique case (kind_q)
               K_DZ: begin
                  quot_o <= '0;
                  ovf_o  <= 1'b0;
               end
               K_SAT: begin
                  quot_o <= S_MAX;
                  ovf_o  <= 1'b1;
                  if (setcc_q) begin
                     cc_quot_o <= S_MAX;
                     cc_ovf_o  <= 1'b1;
                  end
               end
               default: begin
                  quot_o <= fx_quot;
                  ovf_o  <= fx_ovf;
                  if (setcc_q) begin
                     cc_quot_o <= fx_quot;
                     cc_ovf_o  <= fx_ovf;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/sat_divider_chk.sv
module sat_divider_chk #(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          signed_i,
   input logic          busy_o,
   input logic          done_o,
   input logic          dz_trap_o,
   input logic [DW-1:0] quot_o,
   input logic          ovf_o,
   input logic [DW-1:0] cc_quot_o,
   input logic          cc_ovf_o
);

   localparam logic [DW-1:0] S_MAX = {1'b0, {(DW-1){1'b1}}};
   localparam logic [DW-1:0] S_MIN = {1'b1, {(DW-1){1'b0}}};

   logic mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    mode_q <= 1'b0;
      else if (start_i && !busy_o)   mode_q <= signed_i;
   end

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_trap_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      dz_trap_o |-> done_o);

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o);

   assert_busy_to_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (busy_o || done_o));

   assert_trap_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dz_trap_o |-> (quot_o == '0 && !ovf_o && $stable(cc_quot_o) && $stable(cc_ovf_o)));

   assert_unsigned_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o && !mode_q) |-> (&quot_o));

   assert_signed_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && ovf_o && mode_q) |-> (quot_o == S_MAX || quot_o == S_MIN));

   assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(quot_o) && $stable(ovf_o)));

   assert_cc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(cc_quot_o) && $stable(cc_ovf_o)));

endmodule

bind sat_divider sat_divider_chk #(.DW(DW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_i   (start_i),
   .signed_i  (signed_i),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .dz_trap_o (dz_trap_o),
   .quot_o    (quot_o),
   .ovf_o     (ovf_o),
   .cc_quot_o (cc_quot_o),
   .cc_ovf_o  (cc_ovf_o)
);

// File: tb/sat_divider_tb_top.sv
module sat_divider_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int LONG_LAT   = 65;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, signed_i = 1'b0, setcc_i = 1'b0;
   logic [31:0] hi_i = '0, opa_i = '0, opb_i = '0;
   logic        busy_o, done_o, dz_trap_o, ovf_o, cc_ovf_o;
   logic [31:0] quot_o, cc_quot_o;

   int nchk = 0;
   int nerr = 0;

   // behavioural reference state
   bit          exp_busy = 0, exp_done = 0, exp_trap = 0, exp_ovf = 0, exp_ccovf = 0;
   logic [31:0] exp_q = '0, exp_ccq = '0;
   int          remain = 0;
   bit          pend_o, pend_t, pend_cc;
   logic [31:0] pend_q;
   string       pend_tag = "R11";
   string       last_tag = "R11";

   always #(CLK_PERIOD/2) clk = ~clk;

   sat_divider dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i), .setcc_i(setcc_i),
      .hi_i(hi_i), .opa_i(opa_i), .opb_i(opb_i), .busy_o(busy_o), .done_o(done_o),
      .dz_trap_o(dz_trap_o), .quot_o(quot_o), .ovf_o(ovf_o),
      .cc_quot_o(cc_quot_o), .cc_ovf_o(cc_ovf_o)
   );

   task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   // reference division from the requirement text
   task automatic ref_div(input bit sg, input logic [31:0] h, a, b,
                          output logic [31:0] q, output bit o, output bit t,
                          output bit shrt, output string tag);
      logic [63:0] ux, uq;
      longint      sx, sy, sq;
      q = '0; o = 0; t = 0; shrt = 0;
      ux = {h, a};
      if (b == 0) begin
         t = 1; shrt = 1; tag = "R2";
      end else if (!sg) begin
         uq = ux / {32'd0, b};
         if (uq > 64'hFFFF_FFFF) begin q = 32'hFFFF_FFFF; o = 1; tag = "R3"; end
         else begin q = uq[31:0]; tag = "R1"; end
      end else begin
         sx = longint'(ux);
         sy = longint'(int'(b));
         if (ux == 64'h8000_0000_0000_0000 && b == 32'hFFFF_FFFF) begin
            q = 32'h7FFF_FFFF; o = 1; shrt = 1; tag = "R6";
         end else begin
            sq = sx / sy;
            if (sq > 64'sd2147483647) begin q = 32'h7FFF_FFFF; o = 1; tag = "R5"; end
            else if (sq < -64'sd2147483648) begin q = 32'h8000_0000; o = 1; tag = "R5"; end
            else begin q = sq[31:0]; tag = "R4"; end
         end
      end
   endtask

   task automatic compare();
      check(busy_o === exp_busy, "R9 busy_o", 64'(busy_o), 64'(exp_busy));
      check(done_o === exp_done, "R8 done_o", 64'(done_o), 64'(exp_done));
      check(dz_trap_o === exp_trap, "R2 dz_trap_o", 64'(dz_trap_o), 64'(exp_trap));
      check(quot_o === exp_q, {last_tag, " quot_o"}, 64'(quot_o), 64'(exp_q));
      check(ovf_o === exp_ovf, {last_tag, " ovf_o"}, 64'(ovf_o), 64'(exp_ovf));
      check(cc_quot_o === exp_ccq, "R7 cc_quot_o", 64'(cc_quot_o), 64'(exp_ccq));
      check(cc_ovf_o === exp_ccovf, "R7 cc_ovf_o", 64'(cc_ovf_o), 64'(exp_ccovf));
   endtask

   task automatic model_step(input bit st, sg, cc, input logic [31:0] h, a, b);
      bit shrt;
      exp_done = 0;
      exp_trap = 0;
      if (exp_busy) begin
         remain--;
         if (remain == 0) begin
            exp_busy = 0;
            exp_done = 1;
            exp_trap = pend_t;
            exp_q    = pend_q;
            exp_ovf  = pend_o;
            last_tag = pend_tag;
            if (pend_cc && !pend_t) begin
               exp_ccq   = pend_q;
               exp_ccovf = pend_o;
            end
         end
      end else if (st) begin
         ref_div(sg, h, a, b, pend_q, pend_o, pend_t, shrt, pend_tag);
         pend_cc  = cc;
         exp_busy = 1;
         remain   = shrt ? 1 : LONG_LAT;
      end
   endtask

   task automatic cycle(input bit st, sg, cc, input logic [31:0] h, a, b);
      @(negedge clk);
      compare();
      start_i = st; signed_i = sg; setcc_i = cc;
      hi_i = h; opa_i = a; opb_i = b;
      model_step(st, sg, cc, h, a, b);
   endtask

   task automatic idle();
      cycle(0, 0, 0, '0, '0, '0);
   endtask

   task automatic run_op(input bit sg, cc, input logic [31:0] h, a, b);
      cycle(1, sg, cc, h, a, b);
      while (exp_busy) idle();
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check({busy_o, done_o, dz_trap_o, ovf_o, cc_ovf_o} === 5'b0, "R11 reset flags",
            64'({busy_o, done_o, dz_trap_o, ovf_o, cc_ovf_o}), 64'd0);
      check(quot_o === '0 && cc_quot_o === '0, "R11 reset quotients",
            {quot_o, cc_quot_o}, 64'd0);
      rst_n = 1'b1;
      idle();

      // R1 unsigned exact, including a high word
      run_op(0, 1, 32'd0, 32'd100, 32'd7);
      run_op(0, 1, 32'd3, 32'h1234_5678, 32'h1000_0000);
      // R3 unsigned saturation
      run_op(0, 1, 32'd5, 32'd0, 32'd5);
      run_op(0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1);
      // R2 divide by zero in both modes, flags must hold
      run_op(0, 1, 32'd1, 32'd2, 32'd0);
      run_op(1, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd0);
      // R4 signed exact with mixed signs
      run_op(1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2);
      run_op(1, 0, 32'd0, 32'd7, 32'hFFFF_FFFE);
      run_op(1, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1);
      run_op(1, 1, 32'd0, 32'h7FFF_FFFF, 32'd1);
      // R5 signed clamps, exactly at and beyond the limits
      run_op(1, 1, 32'd0, 32'h8000_0000, 32'd1);
      run_op(1, 1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'd1);
      run_op(1, 1, 32'h8000_0000, 32'd0, 32'd3);
      run_op(1, 1, 32'h0000_0001, 32'd0, 32'hFFFF_FFFF);
      // R6 most negative over minus one, short latency
      run_op(1, 1, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF);
      // R7 no flag update when setcc is low
      run_op(0, 0, 32'd0, 32'd9, 32'd3);
      // R9 start while busy is ignored
      cycle(1, 0, 1, 32'd0, 32'd100, 32'd7);
      repeat (10) idle();
      cycle(1, 1, 1, 32'hFFFF_FFFF, 32'd0, 32'd0);
      while (exp_busy) idle();
      // R9 start accepted in the done cycle
      cycle(1, 1, 1, 32'd0, 32'd50, 32'hFFFF_FFFB);
      while (exp_busy) idle();
      cycle(1, 0, 1, 32'd0, 32'd0, 32'd0);
      while (exp_busy) idle();
      idle();
      // mixed operand patterns for R1, R3, R4, R5
      for (int i = 0; i < 24; i++) begin
         logic [31:0] b, h;
         b = $urandom;
         if (i % 3 == 0) b = b >> (i % 29);
         h = (i % 2 == 0) ? ($urandom % (b | 32'd1)) : $urandom;
         run_op(i[1], i[2], h, $urandom, b);
      end
      repeat (3) idle();
      summary();
      $finish;
   end

endmodule